// File: doc/BRIEF.md
# Shift Execution Unit for a Single-Cycle Integer Datapath

This block is the shift-and-add slice of a single-cycle integer execute stage. Each cycle it takes a 32-bit instruction word and the two operand values read from the register file for that instruction. It splits the word into its register-format fields and recognises six shift operations and an unsigned add. From these it produces, in the same cycle, the value to write back, the index of the register to write, and a write-enable flag.

The value being shifted is always the second source operand (rt). The shift distance is chosen per operation. The fixed forms take it from the shift-amount field of the instruction. The variable forms take it from the low bits of the first source operand (rs). One barrel shifter serves left, logical-right and arithmetic-right shifts. The unsigned add lets the downstream logic tell shifts apart from the other register-format operations.

The unit is purely combinational. It holds no state, and its outputs follow its inputs within the same cycle.

Top module: `shx_unit`

## Requirements
- R1: An instruction is accepted only when bits [31:26] are 000000. Any other value there drives `wr_en` to 0.
- R2: funct 000000 shifts rt left by the 5-bit field in bits [10:6], filling the vacated low bits with zeros.
- R3: funct 000010 shifts rt right logically by bits [10:6], filling with zeros. Two examples: 0x00000014 by 2 gives 0x00000005, and 0xF0000000 by 30 gives 0x00000003.
- R4: funct 000011 shifts rt right arithmetically by bits [10:6], copying bit 31 of rt into every vacated position.
- R5: funct 000100, 000110 and 000111 are the variable left, logical-right and arithmetic-right shifts. Their distance is rs[4:0]. Bits [31:5] of rs and the instruction's bits [10:6] have no effect.
- R6: In every shift the data shifted is rt. The value of rs has no effect on a fixed shift.
- R7: funct 100001 writes rs+rt modulo 2^32 and is not treated as a shift. For example, word 0x01C58821 writes to register 17.
- R8: For every accepted operation, `dest_idx` equals bits [15:11] and `wr_en` is 1. A funct outside the seven listed codes drives `wr_en` to 0.
- R9: A shift distance of 0 returns rt unchanged. A distance of 31 is fully supported in all three directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word under execution |
| rs_val | input | 32 | Register value selected by bits [25:21] |
| rt_val | input | 32 | Register value selected by bits [20:16] |
| result | output | 32 | Value to write back |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | High when the result is to be written |

## Verification
The two shift-distance sources can both be live in the same cycle. A variable shift may arrive with a non-zero shift-amount field in the instruction word. Its rs operand may also carry set upper bits that exceed the 5-bit distance. The bench provokes this with variable-shift words whose bits [10:6] hold a distance different from rs[4:0], and with rs values whose upper bits are ones. A result is judged correct only if it matches a shift by rs[4:0] alone. The bench likewise changes rs under fixed shifts to show that rs does not reach the data path.

// File: rtl/shx_pkg.sv
package shx_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;

  localparam logic [5:0] OPC_REG = 6'b000000;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SLLV = 6'b000100;
  localparam logic [5:0] FN_SRLV = 6'b000110;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_ADDU = 6'b100001;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SHL,
    OP_SHR_LOG,
    OP_SHR_ARI,
    OP_ADD
  } op_e;

  typedef struct packed {
    logic [5:0]           opc;
    logic [REG_IDX_W-1:0] rs;
    logic [REG_IDX_W-1:0] rt;
    logic [REG_IDX_W-1:0] rd;
    logic [4:0]           sh;
    logic [5:0]           fn;
  } rfmt_t;

endpackage

// File: rtl/shx_decode.sv
module shx_decode
  import shx_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr,
  output op_e                  op,
  output logic                 amt_from_reg,
  output logic [4:0]           sh_field,
  output logic [REG_IDX_W-1:0] rd_field
);

  rfmt_t f;
  assign f = rfmt_t'(instr);
  assign sh_field = f.sh;
  assign rd_field = f.rd;

  always_comb begin
    op = OP_NONE;
    amt_from_reg = 1'b0;
    if (f.opc == OPC_REG) begin
      unique case (f.fn)
        FN_SLL:  op = OP_SHL;
        FN_SRL:  op = OP_SHR_LOG;
        FN_SRA:  op = OP_SHR_ARI;
        FN_SLLV: begin op = OP_SHL;     amt_from_reg = 1'b1; end
        FN_SRLV: begin op = OP_SHR_LOG; amt_from_reg = 1'b1; end
        FN_SRAV: begin op = OP_SHR_ARI; amt_from_reg = 1'b1; end
        FN_ADDU: op = OP_ADD;
        default: op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/shx_operand.sv
module shx_operand #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [4:0]      sh_field,
  input  logic            amt_from_reg,
  output logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] data
);

  assign amt  = amt_from_reg ? rs_val[SHW-1:0] : sh_field[SHW-1:0];
  assign data = rt_val;

endmodule

// File: rtl/shx_barrel.sv
module shx_barrel #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            dir_left,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);

  logic            fill;
  logic [XLEN-1:0] pre;
  logic [XLEN-1:0] stg [SHW+1];
  logic [XLEN-1:0] post;

  assign fill = arith & ~dir_left & din[XLEN-1];

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_in
    assign pre[i] = dir_left ? din[XLEN-1-i] : din[i];
  end

  assign stg[0] = pre;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_rev_out
    assign post[i] = dir_left ? stg[SHW][XLEN-1-i] : stg[SHW][i];
  end

  assign dout = post;

  always_comb begin
    assert_zero_pass_R9: assert (amt != '0 || dout == din)
      else $error("zero distance altered data");
    assert_left_zero_fill_R2: assert (!(dir_left && amt != '0) || dout[0] == 1'b0)
      else $error("left shift low bit not zero");
    assert_right_fill_R4: assert (dir_left || amt == '0 || dout[XLEN-1] == (arith & din[XLEN-1]))
      else $error("right shift top bit wrong fill");
  end

endmodule

// File: rtl/shx_unit.sv
module shx_unit
  import shx_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic [XLEN-1:0]      rs_val,
  input  logic [XLEN-1:0]      rt_val,
  output logic [XLEN-1:0]      result,
  output logic [REG_IDX_W-1:0] dest_idx,
  output logic                 wr_en
);

  op_e                  op;
  logic                 amt_from_reg;
  logic [4:0]           sh_field;
  logic [REG_IDX_W-1:0] rd_field;
  logic [SHW-1:0]       amt;
  logic [XLEN-1:0]      sh_data;
  logic [XLEN-1:0]      sh_out;
  logic [XLEN-1:0]      sum;

  shx_decode u_dec (
    .instr        (instr),
    .op           (op),
    .amt_from_reg (amt_from_reg),
    .sh_field     (sh_field),
    .rd_field     (rd_field)
  );

  shx_operand #(.XLEN(XLEN)) u_opnd (
    .rs_val       (rs_val),
    .rt_val       (rt_val),
    .sh_field     (sh_field),
    .amt_from_reg (amt_from_reg),
    .amt          (amt),
    .data         (sh_data)
  );

  shx_barrel #(.XLEN(XLEN)) u_bsh (
    .din      (sh_data),
    .amt      (amt),
    .dir_left (op == OP_SHL),
    .arith    (op == OP_SHR_ARI),
    .dout     (sh_out)
  );

  assign sum = rs_val + rt_val;

  always_comb begin
    unique case (op)
      OP_ADD:  result = sum;
      OP_NONE: result = '0;
      default: result = sh_out;
    endcase
  end

  assign wr_en    = (op != OP_NONE);
  assign dest_idx = rd_field;

  always_comb begin
    assert_opcode_gate_R1: assert (!wr_en || instr[31:26] == OPC_REG)
      else $error("write enabled for non register-format word");
    assert_dest_field_R8: assert (dest_idx == instr[15:11])
      else $error("destination index differs from rd field");
    assert_add_path_R7: assert (!(wr_en && instr[5:0] == FN_ADDU) || result == rs_val + rt_val)
      else $error("unsigned add result wrong");
  end

endmodule

// File: tb/shx_unit_tb.sv
module shx_unit_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr, rs_val, rt_val;
  logic [31:0] result;
  logic [4:0]  dest_idx;
  logic        wr_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  shx_unit u_dut (
    .instr    (instr),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .result   (result),
    .dest_idx (dest_idx),
    .wr_en    (wr_en)
  );

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd,
                                     input logic [4:0] sh, input logic [5:0] fn);
    return {opc, rs, rt, rd, sh, fn};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; rs_val = a; rt_val = b;
    #2;
  endtask

  task automatic expect_op(input string tag, input logic [31:0] exp_res, input logic [4:0] exp_rd);
    check({tag, " wr_en"}, {31'b0, wr_en}, 32'd1);
    check({tag, " result"}, result, exp_res);
    check({tag, " dest"}, {27'b0, dest_idx}, {27'b0, exp_rd});
  endtask

  task automatic t_idle();
    apply(32'h0, 32'hDEAD_BEEF, 32'h1234_5678);
    expect_op("R9 zero word is sll by 0", 32'h1234_5678, 5'd0);
    apply(mk(6'h23, 5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'h1, 32'h2);
    check("R1 load opcode no write", {31'b0, wr_en}, 32'd0);
    apply(mk(6'h01, 5'd1, 5'd2, 5'd3, 5'd4, 6'h00), 32'h1, 32'hF);
    check("R1 nonzero opcode sll funct no write", {31'b0, wr_en}, 32'd0);
  endtask

  task automatic t_sll();
    apply(mk(6'h0, 5'd0, 5'd4, 5'd9, 5'd4, 6'b000000), 32'h0, 32'h8000_00FF);
    expect_op("R2 sll 4", 32'h0000_0FF0, 5'd9);
  endtask

  task automatic t_srl();
    apply(mk(6'h0, 5'd0, 5'd4, 5'd10, 5'd2, 6'b000010), 32'h0, 32'h0000_0014);
    expect_op("R3 srl 2", 32'h0000_0005, 5'd10);
    apply(mk(6'h0, 5'd0, 5'd4, 5'd11, 5'd30, 6'b000010), 32'h0, 32'hF000_0000);
    expect_op("R3 srl 30", 32'h0000_0003, 5'd11);
  endtask

  task automatic t_sra();
    apply(mk(6'h0, 5'd0, 5'd4, 5'd12, 5'd4, 6'b000011), 32'h0, 32'h8000_0010);
    expect_op("R4 sra neg", 32'hF800_0001, 5'd12);
    apply(mk(6'h0, 5'd0, 5'd4, 5'd13, 5'd28, 6'b000011), 32'h0, 32'h7000_0000);
    expect_op("R4 sra pos", 32'h0000_0007, 5'd13);
  endtask

  task automatic t_var();
    logic [31:0] v;
    v = 32'hA5C3_0F81;
    apply(mk(6'h0, 5'd3, 5'd4, 5'd14, 5'd7, 6'b000100), 32'hFFFF_FFE3, v);
    expect_op("R5 sllv rs low5", v << 3, 5'd14);
    apply(mk(6'h0, 5'd3, 5'd4, 5'd15, 5'd1, 6'b000110), 32'h0000_0FE9, v);
    expect_op("R5 srlv rs low5", v >> 9, 5'd15);
    apply(mk(6'h0, 5'd3, 5'd4, 5'd16, 5'd2, 6'b000111), 32'h8000_0025, v);
    expect_op("R5 srav rs low5", 32'($signed(v) >>> 5), 5'd16);
  endtask

  task automatic t_rs_indep();
    apply(mk(6'h0, 5'd7, 5'd4, 5'd18, 5'd5, 6'b000010), 32'h0000_0000, 32'hCAFE_F00D);
    expect_op("R6 srl rs=0", 32'hCAFE_F00D >> 5, 5'd18);
    apply(mk(6'h0, 5'd7, 5'd4, 5'd18, 5'd5, 6'b000010), 32'hFFFF_FFFF, 32'hCAFE_F00D);
    expect_op("R6 srl rs=ones", 32'hCAFE_F00D >> 5, 5'd18);
    apply(mk(6'h0, 5'd7, 5'd4, 5'd19, 5'd3, 6'b000000), 32'h0000_001F, 32'h0000_0001);
    expect_op("R6 sll ignores rs", 32'h0000_0008, 5'd19);
  endtask

  task automatic t_addu();
    apply(32'h01C5_8821, 32'hFFFF_FFFF, 32'h0000_0002);
    expect_op("R7 addu wrap", 32'h0000_0001, 5'd17);
    apply(32'h01C5_8821, 32'h1234_0000, 32'h0000_5678);
    expect_op("R7 addu plain", 32'h1234_5678, 5'd17);
  endtask

  task automatic t_bad_funct();
    apply(mk(6'h0, 5'd1, 5'd2, 5'd20, 5'd0, 6'b001000), 32'h5, 32'h6);
    check("R8 unknown funct 001000", {31'b0, wr_en}, 32'd0);
    apply(mk(6'h0, 5'd1, 5'd2, 5'd20, 5'd0, 6'b000001), 32'h5, 32'h6);
    check("R8 unknown funct 000001", {31'b0, wr_en}, 32'd0);
    apply(mk(6'h0, 5'd1, 5'd2, 5'd31, 5'd1, 6'b000000), 32'h0, 32'h1);
    expect_op("R8 rd 31", 32'h2, 5'd31);
  endtask

  task automatic t_edges();
    apply(mk(6'h0, 5'd0, 5'd4, 5'd1, 5'd0, 6'b000011), 32'h0, 32'h8765_4321);
    expect_op("R9 sra 0", 32'h8765_4321, 5'd1);
    apply(mk(6'h0, 5'd0, 5'd4, 5'd2, 5'd31, 6'b000000), 32'h0, 32'h0000_0003);
    expect_op("R9 sll 31", 32'h8000_0000, 5'd2);
    apply(mk(6'h0, 5'd0, 5'd4, 5'd3, 5'd31, 6'b000010), 32'h0, 32'h8000_0000);
    expect_op("R9 srl 31", 32'h0000_0001, 5'd3);
    apply(mk(6'h0, 5'd0, 5'd4, 5'd5, 5'd31, 6'b000011), 32'h0, 32'h8000_0000);
    expect_op("R9 sra 31", 32'hFFFF_FFFF, 5'd5);
    apply(mk(6'h0, 5'd6, 5'd4, 5'd6, 5'd0, 6'b000111), 32'hFFFF_FFFF, 32'h4000_0000);
    expect_op("R9 srav 31 pos", 32'h0000_0000, 5'd6);
  endtask

  initial begin
    instr = '0; rs_val = '0; rt_val = '0;
    repeat (2) @(negedge clk);
    t_idle();
    t_sll();
    t_srl();
    t_sra();
    t_var();
    t_rs_indep();
    t_addu();
    t_bad_funct();
    t_edges();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule